// File: doc/BRIEF.md
# Warp Cache-Line Transaction Counter

This block examines one warp-wide memory request at a time. A request carries a byte address for each of 32 lockstep lanes together with an active-lane mask. The block works out how many distinct 32-byte cache lines the active lanes touch. That number is the count of L2 read transactions the request would generate. Lanes whose mask bit is clear are left out of the count.

Each result appears as a line count with a one-cycle valid pulse. The block also keeps two saturating running totals: one of transactions and one of requests. A performance-analysis harness or a functional trace replayer can feed warp loads into it and read the totals at the end of a kernel phase.

A new request is taken when `req_ready` is high. The block then spends one cycle evaluating it, so it accepts at most one request every two cycles.

Top module: `warp_line_counter`

## Requirements
- R1: After a synchronous active-high `rst`, `res_valid` is 0, `req_ready` is 1, and both totals are 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly one cycle. The next edge raises `res_valid` for exactly one cycle, together with that request's count. A `req_valid` held high while `req_ready` is 0 is not taken.
- R3: Lane i's address is `req_addr[32*i +: 32]`, and its line is identified by address bits [31:5]. Active lanes that share a line count once, including when a run of addresses wraps from the top of the address space to zero.
- R4: Lane i is active when `req_mask[i]` is 1. Lanes with mask bit 0 add nothing to the count, whatever their address.
- R5: Thirty-two active lanes reading consecutive 4-byte elements from a line-aligned base yield a count of 4.
- R6: Thirty-two active lanes with pairwise distinct lines yield 32. Thirty-two active lanes with the same address yield 1.
- R7: A request with an all-zero mask yields a count of 0 and still adds 1 to the request total.
- R8: Each result adds its count to `total_txn` and adds 1 to `total_req`.
- R9: Both totals saturate at 2^TOT_W-1 and never wrap.
- R10: A synchronous `clr` sets both totals to 0 at the next edge. If a result completes at that same edge, the clear wins in the totals, while `res_valid` and `res_lines` still report the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of both totals |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 1024 | 32 lane byte addresses, lane i at bits [32*i+31:32*i] |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| res_valid | output | 1 | One-cycle pulse marking a new count |
| res_lines | output | 6 | Distinct lines touched by the last request |
| total_txn | output | TOT_W | Saturating sum of line counts |
| total_req | output | TOT_W | Saturating number of completed requests |

## Verification
Two of this block's functions can land on the same edge: a clear of the totals and the accumulation of a request that is finishing evaluation. The bench provokes this by raising `clr` in the cycle when `req_ready` is low. It then judges that the totals read zero while `res_lines` still carries the request's count, and that the following request accumulates from zero. Saturation and a new addition also meet on one edge. The bench drives this with a narrowed total width and expects the totals to hold at their ceiling.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

    localparam int unsigned LANE_COUNT = 32;
    localparam int unsigned ADDR_BITS  = 32;
    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned LINE_OFS   = $clog2(LINE_BYTES);
    localparam int unsigned TAG_BITS   = ADDR_BITS - LINE_OFS;
    localparam int unsigned CNT_BITS   = $clog2(LANE_COUNT + 1);

    typedef logic [LANE_COUNT-1:0]           lane_mask_t;
    typedef logic [TAG_BITS-1:0]             line_tag_t;
    typedef logic [CNT_BITS-1:0]             line_cnt_t;
    typedef logic [LANE_COUNT*ADDR_BITS-1:0] lane_addr_vec_t;

    typedef struct packed {
        lane_mask_t     mask;
        lane_addr_vec_t addr;
    } warp_req_t;

    typedef enum logic {
        PH_IDLE,
        PH_EVAL
    } phase_e;

    // Line tag of one lane: the address with the in-line offset dropped.
    function automatic line_tag_t lane_tag(lane_addr_vec_t v, int unsigned lane);
        return v[lane*ADDR_BITS + LINE_OFS +: TAG_BITS];
    endfunction

    function automatic line_cnt_t count_ones(lane_mask_t m);
        line_cnt_t c;
        c = '0;
        for (int unsigned i = 0; i < LANE_COUNT; i++) begin
            c = c + line_cnt_t'(m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/wlc_capture.sv
module wlc_capture
    import wlc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  lane_addr_vec_t req_addr,
    input  lane_mask_t     req_mask,
    output logic           req_ready,
    output warp_req_t      held,
    output logic           eval
);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase     <= PH_EVAL;
                        held.mask <= req_mask;
                        held.addr <= req_addr;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase == PH_IDLE);
    assign eval      = (phase == PH_EVAL);

    // R2
    accept_closes_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    busy_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

endmodule

// File: rtl/wlc_unique.sv
module wlc_unique
    import wlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  warp_req_t  req,
    output lane_mask_t first_hit,
    output line_cnt_t  lines
);

    line_tag_t              tags [LANE_COUNT];
    logic [LANE_COUNT-1:0]  seen [LANE_COUNT];

    for (genvar gi = 0; gi < LANE_COUNT; gi++) begin : g_lane
        assign tags[gi] = lane_tag(req.addr, gi);
        for (genvar gj = 0; gj < LANE_COUNT; gj++) begin : g_prev
            if (gj < gi) begin : g_cmp
                assign seen[gi][gj] = req.mask[gj] && (tags[gj] == tags[gi]);
            end else begin : g_none
                assign seen[gi][gj] = 1'b0;
            end
        end
        assign first_hit[gi] = req.mask[gi] && !(|seen[gi]);
    end

    assign lines = count_ones(first_hit);

    // R4
    inactive_lane_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (first_hit & ~req.mask) == '0);

    // R3
    some_line_when_active_chk: assert property (@(posedge clk) disable iff (rst)
        (req.mask != '0) |-> (first_hit != '0));

    // R6
    count_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(first_hit) <= $countones(req.mask));

endmodule

// File: rtl/wlc_accum.sv
module wlc_accum
    import wlc_pkg::*;
#(
    parameter int unsigned TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  line_cnt_t        add_lines,
    output logic [TOT_W-1:0] total_txn,
    output logic [TOT_W-1:0] total_req
);

    localparam int unsigned      SUM_W = TOT_W + 1;
    localparam logic [TOT_W-1:0] CEIL  = '1;

    logic [SUM_W-1:0] txn_sum;
    logic [TOT_W-1:0] txn_next;
    logic [TOT_W-1:0] req_next;

    assign txn_sum  = {1'b0, total_txn} + SUM_W'(add_lines);
    assign txn_next = txn_sum[TOT_W] ? CEIL : txn_sum[TOT_W-1:0];
    assign req_next = (total_req == CEIL) ? CEIL : total_req + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total_txn <= '0;
            total_req <= '0;
        end else if (add_en) begin
            total_txn <= txn_next;
            total_req <= req_next;
        end
    end

    // R9
    txn_never_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> total_txn >= $past(total_txn));

    // R8
    req_steps_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (add_en && !clr && total_req != CEIL) |=> total_req == $past(total_req) + 1'b1);

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total_txn == '0 && total_req == '0));

endmodule

// File: rtl/warp_line_counter.sv
module warp_line_counter
    import wlc_pkg::*;
#(
    parameter int unsigned TOT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [LANE_COUNT*ADDR_BITS-1:0] req_addr,
    input  logic [LANE_COUNT-1:0]           req_mask,
    output logic                            res_valid,
    output logic [CNT_BITS-1:0]             res_lines,
    output logic [TOT_W-1:0]                total_txn,
    output logic [TOT_W-1:0]                total_req
);

    warp_req_t  held;
    logic       eval;
    lane_mask_t first_hit;
    line_cnt_t  lines;

    wlc_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_mask  (req_mask),
        .req_ready (req_ready),
        .held      (held),
        .eval      (eval)
    );

    wlc_unique u_unique (
        .clk       (clk),
        .rst       (rst),
        .req       (held),
        .first_hit (first_hit),
        .lines     (lines)
    );

    wlc_accum #(.TOT_W(TOT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .add_en    (eval),
        .add_lines (lines),
        .total_txn (total_txn),
        .total_req (total_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_lines <= '0;
        end else begin
            res_valid <= eval;
            if (eval) begin
                res_lines <= lines;
            end
        end
    end

    // R2
    result_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> res_valid);

    // R2
    result_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R6
    result_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_lines <= CNT_BITS'(LANE_COUNT));

endmodule

// File: tb/warp_line_counter_test.sv
module warp_line_counter_test;

    localparam int unsigned TW   = 8;
    localparam logic [31:0] CEIL = 32'd255;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [31:0] mask;
        logic [31:0] lines;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'd4,        32'hFFFF_FFFF, 32'd4,  4'd5},
        '{32'h0000_1000, 32'd32,       32'hFFFF_FFFF, 32'd32, 4'd6},
        '{32'h0000_0040, 32'd0,        32'hFFFF_FFFF, 32'd1,  4'd6},
        '{32'h0000_0000, 32'd4,        32'h0000_00FF, 32'd1,  4'd4},
        '{32'h0000_0000, 32'd4,        32'h8000_0001, 32'd2,  4'd4},
        '{32'h0000_001C, 32'd4,        32'hFFFF_FFFF, 32'd5,  4'd3},
        '{32'h0000_0000, 32'd8,        32'h5555_5555, 32'd8,  4'd4},
        '{32'h0000_0000, 32'd4,        32'h0000_0000, 32'd0,  4'd7},
        '{32'hFFFF_FFE0, 32'd4,        32'hFFFF_FFFF, 32'd4,  4'd3},
        '{32'h0000_0000, 32'd16,       32'h0000_FFFF, 32'd8,  4'd4},
        '{32'h0001_0000, 32'h0001_0000, 32'hFFFF_FFFF, 32'd32, 4'd6}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1023:0] req_addr = '0;
    logic [31:0]   req_mask = '0;
    logic          res_valid;
    logic [5:0]    res_lines;
    logic [TW-1:0] total_txn;
    logic [TW-1:0] total_req;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_txn = 0;
    logic [31:0] exp_req = 0;

    always #4 clk = ~clk;

    warp_line_counter #(.TOT_W(TW)) uut (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_mask  (req_mask),
        .res_valid (res_valid),
        .res_lines (res_lines),
        .total_txn (total_txn),
        .total_req (total_req)
    );

    function automatic string rq_name(logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R?";
        endcase
    endfunction

    function automatic logic [1023:0] build(logic [31:0] base, logic [31:0] stride);
        logic [1023:0] v;
        for (int i = 0; i < 32; i++) begin
            v[32*i +: 32] = base + stride * i;
        end
        return v;
    endfunction

    function automatic logic [31:0] sat(logic [31:0] a, logic [31:0] b);
        return (a + b > CEIL) ? CEIL : a + b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Returns at the negedge after the result edge.
    task automatic send(input logic [31:0] base, stride, mask, input bit with_clr);
        @(negedge clk);
        req_addr  = build(base, stride);
        req_mask  = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low while evaluating", 32'(req_ready), 0);
        if (with_clr) clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R2 result valid", 32'(res_valid), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 res_valid after reset", 32'(res_valid), 0);
        chk("R1 ready after reset", 32'(req_ready), 1);
        chk("R1 txn after reset", 32'(total_txn), 0);
        chk("R1 req after reset", 32'(total_req), 0);
        rst = 1'b0;

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            send(VECS[k].base, VECS[k].stride, VECS[k].mask, 1'b0);
            exp_txn = sat(exp_txn, VECS[k].lines);
            exp_req = sat(exp_req, 1);
            chk(rq_name(VECS[k].rq), 32'(res_lines), VECS[k].lines);
            chk("R8 txn total", 32'(total_txn), exp_txn);
            chk("R8 req total", 32'(total_req), exp_req);
        end
        @(negedge clk);
        chk("R2 pulse ends", 32'(res_valid), 0);

        // R2: req_valid held high through the busy cycle is taken only twice in four edges
        req_addr  = build(32'h0, 32'd4);
        req_mask  = 32'hFFFF_FFFF;
        req_valid = 1'b1;
        @(negedge clk);
        chk("R2 held valid busy", 32'(req_ready), 0);
        @(negedge clk);
        chk("R2 held valid first result", 32'(res_valid), 1);
        @(negedge clk);
        chk("R2 held valid second accept", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        exp_txn = sat(exp_txn, 8);
        exp_req = sat(exp_req, 2);
        chk("R2 held valid txn", 32'(total_txn), exp_txn);
        chk("R2 held valid req", 32'(total_req), exp_req);

        // R10: clear on the same edge as a finishing result
        send(32'h1000, 32'd32, 32'h0000_0FFF, 1'b1);
        chk("R10 result kept under clear", 32'(res_lines), 12);
        chk("R10 txn cleared", 32'(total_txn), 0);
        chk("R10 req cleared", 32'(total_req), 0);
        send(32'h0, 32'd4, 32'hFFFF_FFFF, 1'b0);
        exp_txn = 4; exp_req = 1;
        chk("R10 accumulate from zero", 32'(total_txn), exp_txn);
        chk("R10 req from zero", 32'(total_req), exp_req);

        // R10: idle clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_txn = 0; exp_req = 0;
        chk("R10 idle clear txn", 32'(total_txn), 0);
        chk("R10 idle clear req", 32'(total_req), 0);

        // R9: transaction saturation
        for (int k = 0; k < 9; k++) begin
            send(32'h0, 32'd32, 32'hFFFF_FFFF, 1'b0);
            exp_txn = sat(exp_txn, 32);
            exp_req = sat(exp_req, 1);
            chk("R9 txn saturating", 32'(total_txn), exp_txn);
        end
        chk("R9 txn at ceiling", 32'(total_txn), CEIL);

        // R7 and R9: empty masks still count requests, up to the ceiling
        for (int k = 0; k < 260; k++) begin
            send(32'h0, 32'd4, 32'h0, 1'b0);
            exp_req = sat(exp_req, 1);
            if (k == 0) chk("R7 zero mask count", 32'(res_lines), 0);
        end
        chk("R9 req at ceiling", 32'(total_req), CEIL);
        chk("R7 txn unchanged by empty masks", 32'(total_txn), CEIL);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk("R1 txn after late reset", 32'(total_txn), 0);
        chk("R1 req after late reset", 32'(total_req), 0);
        chk("R1 ready after late reset", 32'(req_ready), 1);

        finish_run();
    end

endmodule